// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block serialises characters onto a single asynchronous line. Software writes a character into a one-deep holding register. A hidden shift stage takes the character from there as soon as it is free. It then sends a low start bit, the data bits least significant first, and a high stop bit. The line rests high between frames. Bit boundaries advance only on a one-cycle baud tick supplied from outside. A frame carries eight data bits, or nine when the nine-bit mode is selected; the ninth bit is whatever the writer supplied and is not computed by the block.

Software feeds the block by watching a buffer-empty flag. The flag is set whenever the transmitter is enabled and nothing is queued behind a busy shift stage. It is driven only by hardware and lags a write by two cycles. An interrupt output is the flag gated by an interrupt enable. When a character is queued behind a running frame, it is handed over one cycle after the running frame's stop bit ends. Its start bit therefore follows with no idle bit period in between.

Top module: `dbtx_top`

## Requirements
- R1: While the shift stage is not busy, or while the transmitter is disabled, `tx_line` is 1.
- R2: A frame is one 0 start bit, then the data bits with bit 0 first, then one 1 stop bit. Each bit stays on the line until a cycle with `baud_tick` = 1 ends it.
- R3: If `nine_mode` is 1 when a character enters the shift stage, the frame carries 9 data bits, and `wr_bit9` (latched with the write) is sent after data bit 7. If `nine_mode` is 0, the frame carries 8 data bits.
- R4: If a write (`wr_stb` = 1 in cycle c) finds the shift stage idle and nothing queued, the character enters the shift stage at the end of cycle c+1. `tx_line` is 0 and `tx_busy` is 1 in cycle c+2.
- R5: A character written while a frame is in progress waits. `tx_busy` is 0 for exactly one cycle after the stop bit ends, and in the next cycle the new start bit (`tx_line` = 0) begins.
- R6: `empty_flag` equals, delayed by one register stage, "enabled and not (character queued while the shift stage is busy)". A write in cycle c leaves the flag unchanged in cycle c+1 and shows its effect from cycle c+2.
- R7: `tx_irq` = `empty_flag` AND `irq_en`. The value of `empty_flag` does not depend on `irq_en`.
- R8: The transmitter is enabled only when `tx_en` = 1, `port_en` = 1 and `sync_mode` = 0. While disabled, writes are ignored and `empty_flag` is 0. The flag becomes 1 one cycle after enabling with an empty buffer.
- R9: A write while a character is already queued behind a busy shift stage is discarded, and the sticky `overrun` output is set. It stays 1 until the transmitter is disabled.
- R10: Disabling the transmitter mid-frame aborts the frame. From the next cycle, `tx_line` = 1, `tx_busy` = 0, `empty_flag` = 0 and `overrun` = 0, and any queued character is dropped.
- R11: `tx_busy` is 1 from the cycle after the handoff into the shift stage until the tick that ends the stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable |
| port_en | input | 1 | Serial port enable |
| sync_mode | input | 1 | Synchronous mode select; must be 0 to transmit |
| nine_mode | input | 1 | Nine data bits per frame when 1 |
| irq_en | input | 1 | Interrupt enable for the empty flag |
| baud_tick | input | 1 | One-cycle pulse ending each bit period |
| wr_stb | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character data |
| wr_bit9 | input | 1 | Ninth data bit for the character |
| tx_line | output | 1 | Serial output, idles high |
| tx_busy | output | 1 | Shift stage is sending a frame |
| empty_flag | output | 1 | Holding register free to accept a character |
| tx_irq | output | 1 | Empty flag gated by irq_en |
| overrun | output | 1 | Sticky: a write was lost to a full holding register |

## Verification
A corrupt holding register or a missed handoff shows up on `tx_line` at the next baud tick. It appears as a wrong data bit or a missing start bit, or as `tx_busy` staying low one cycle too long after a stop bit. A flag register that samples the wrong condition is visible at `empty_flag` within two cycles of any write to a busy transmitter. A stuck shift position appears as a frame whose stop bit is not high at the expected tick. The bench compares every output against a behavioural queue model on every cycle. It also decodes the line at the tick rate, so these faults surface within one bit period.

// File: rtl/dbtx_pkg.sv
package dbtx_pkg;
  localparam int unsigned MAX_WORD = 16;

  // Level on the line for frame position pos: 0 = start, 1..nbits = data, beyond = stop.
  function automatic logic frame_level(input logic [MAX_WORD-1:0] word,
                                       input int unsigned pos,
                                       input int unsigned nbits);
    if (pos == 0) return 1'b0;
    else if (pos <= nbits) return word[4'(pos - 1)];
    else return 1'b1;
  endfunction

  // Index of the stop-bit position for a frame with nbits data bits.
  function automatic int unsigned stop_pos(input int unsigned nbits);
    return nbits + 1;
  endfunction
endpackage

// File: rtl/dbtx_hold.sv
module dbtx_hold #(
  parameter int unsigned W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         wr_ok,
  input  logic [W-1:0] wr_word,
  input  logic         take,
  input  logic         shift_busy,
  output logic         hold_valid,
  output logic [W-1:0] hold_word,
  output logic         pending,
  output logic         overrun
);
  logic accept;
  logic lost_write;

  assign pending    = hold_valid & shift_busy;
  assign accept     = wr_ok & ~pending;
  assign lost_write = wr_ok & pending;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      hold_valid <= 1'b0;
      hold_word  <= '0;
    end else if (accept) begin
      hold_valid <= 1'b1;
      hold_word  <= wr_word;
    end else if (take) begin
      hold_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) overrun <= 1'b0;
    else if (lost_write) overrun <= 1'b1;
  end

  // R9: overrun stays set while the transmitter remains enabled
  a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !clr |=> overrun);

  // R9: a lost write leaves the queued character in place
  a_r9_queue_kept: assert property (@(posedge clk) disable iff (!rst_n)
    lost_write && !clr |=> hold_valid && $stable(hold_word));
endmodule

// File: rtl/dbtx_shift.sv
module dbtx_shift
  import dbtx_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        load,
  input  logic [DW:0] load_word,
  input  logic        load_nine,
  input  logic        tick,
  output logic        line,
  output logic        busy,
  output logic        stop_done
);
  localparam int unsigned POS_W = $clog2(DW + 3);

  logic [POS_W-1:0] pos_q;
  logic [DW:0]      word_q;
  logic             nine_q;
  logic [POS_W-1:0] last_pos;

  assign last_pos  = POS_W'(stop_pos(nine_q ? DW + 1 : DW));
  assign stop_done = busy & tick & (pos_q == last_pos);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      busy   <= 1'b0;
      pos_q  <= '0;
      word_q <= '0;
      nine_q <= 1'b0;
    end else if (load) begin
      busy   <= 1'b1;
      pos_q  <= '0;
      word_q <= load_word;
      nine_q <= load_nine;
    end else if (busy && tick) begin
      if (stop_done) busy <= 1'b0;
      else pos_q <= pos_q + 1'b1;
    end
  end

  assign line = busy ? frame_level(MAX_WORD'(word_q), 32'(pos_q), nine_q ? DW + 1 : DW)
                     : 1'b1;

  // R1: the line rests at mark outside a frame
  a_r1_idle_mark: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> line);

  // R4: a handoff starts a frame with a space start bit
  a_r4_start_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    load && !clr |=> busy && !line);

  // R11: busy only ends through the stop-bit tick or an abort
  a_r11_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !stop_done && !clr |=> busy);

  // R2: the final bit of every frame is a mark
  a_r2_stop_is_mark: assert property (@(posedge clk) disable iff (!rst_n)
    stop_done |-> line);
endmodule

// File: rtl/dbtx_flag.sv
module dbtx_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic enabled,
  input  logic pending,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n) flag <= 1'b0;
    else flag <= enabled & ~pending;
  end
endmodule

// File: rtl/dbtx_top.sv
module dbtx_top #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_en,
  input  logic          port_en,
  input  logic          sync_mode,
  input  logic          nine_mode,
  input  logic          irq_en,
  input  logic          baud_tick,
  input  logic          wr_stb,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_bit9,
  output logic          tx_line,
  output logic          tx_busy,
  output logic          empty_flag,
  output logic          tx_irq,
  output logic          overrun
);
  localparam int unsigned WORD_W = DW + 1;

  logic              enabled;
  logic              wr_ok;
  logic              load;
  logic              hold_valid;
  logic [WORD_W-1:0] hold_word;
  logic              pending;
  logic              stop_done;

  assign enabled = tx_en & port_en & ~sync_mode;
  assign wr_ok   = wr_stb & enabled;
  assign load    = enabled & hold_valid & ~tx_busy;
  assign tx_irq  = empty_flag & irq_en;

  dbtx_hold #(.W(WORD_W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (~enabled),
    .wr_ok      (wr_ok),
    .wr_word    ({wr_bit9, wr_data}),
    .take       (load),
    .shift_busy (tx_busy),
    .hold_valid (hold_valid),
    .hold_word  (hold_word),
    .pending    (pending),
    .overrun    (overrun)
  );

  dbtx_shift #(.DW(DW)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (~enabled),
    .load      (load),
    .load_word (hold_word),
    .load_nine (nine_mode),
    .tick      (baud_tick),
    .line      (tx_line),
    .busy      (tx_busy),
    .stop_done (stop_done)
  );

  dbtx_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .enabled (enabled),
    .pending (pending),
    .flag    (empty_flag)
  );

  // R5: a queued character is handed over the cycle after the stop bit ends
  a_r5_handoff: assert property (@(posedge clk) disable iff (!rst_n)
    stop_done && hold_valid && enabled |=> load || !enabled);

  // R6: a character queued behind a busy frame clears the flag one stage later
  a_r6_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |=> !empty_flag);

  // R10: disabling returns everything to idle on the next cycle
  a_r10_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !enabled |=> tx_line && !tx_busy && !empty_flag && !overrun);

  // R8: the flag is never up while the transmitter has been disabled
  a_r8_flag_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    empty_flag |-> $past(enabled));
endmodule

// File: tb/tb_dbtx_top.sv
module tb_dbtx_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 0, port_en = 0, sync_mode = 0, nine_mode = 0, irq_en = 0;
  logic baud_tick = 0, wr_stb = 0, wr_bit9 = 0;
  logic [7:0] wr_data = '0;
  logic tx_line, tx_busy, empty_flag, tx_irq, overrun;

  int checks = 0;
  int errors = 0;
  bit cmp_on = 0;
  bit tick_run = 0;
  int tick_cnt = 0;

  always #5 clk = ~clk;

  dbtx_top dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .port_en(port_en), .sync_mode(sync_mode),
    .nine_mode(nine_mode), .irq_en(irq_en), .baud_tick(baud_tick), .wr_stb(wr_stb),
    .wr_data(wr_data), .wr_bit9(wr_bit9), .tx_line(tx_line), .tx_busy(tx_busy),
    .empty_flag(empty_flag), .tx_irq(tx_irq), .overrun(overrun)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // tick every 4 cycles
  always @(negedge clk) begin
    if (tick_run && tick_cnt == 3) begin
      baud_tick <= 1'b1;
      tick_cnt  <= 0;
    end else begin
      baud_tick <= 1'b0;
      if (tick_run) tick_cnt <= tick_cnt + 1;
    end
  end

  // behavioural reference model
  int m_q[$];
  int exp_q[$];
  bit m_active = 0, m_flag = 0, m_ovf = 0;
  int m_pos = 0, m_len = 10, m_word = 0;

  function automatic bit m_line();
    int fr;
    if (!m_active) return 1'b1;
    fr = (1 << (m_len - 1)) | ((m_word & ((1 << (m_len - 2)) - 1)) << 1);
    return 1'((fr >> m_pos) & 1);
  endfunction

  always @(posedge clk) begin
    bit en, waiting, loaded;
    en = tx_en && port_en && !sync_mode;
    if (!rst_n || !en) begin
      m_q.delete(); exp_q.delete();
      m_active = 0; m_pos = 0; m_flag = 0; m_ovf = 0;
    end else begin
      waiting = (m_q.size() > 0) && m_active;
      loaded  = (m_q.size() > 0) && !m_active;
      if (loaded) begin
        m_word = m_q.pop_front();
        m_active = 1; m_pos = 0; m_len = nine_mode ? 11 : 10;
      end else if (m_active && baud_tick) begin
        if (m_pos == m_len - 1) m_active = 0;
        else m_pos++;
      end
      if (wr_stb) begin
        if (waiting) m_ovf = 1;
        else begin
          m_q.push_back({wr_bit9, wr_data});
          exp_q.push_back({wr_bit9, wr_data});
        end
      end
      m_flag = !waiting;
    end
  end

  // every-cycle comparison, 3 ns after the edge
  always @(posedge clk) begin
    #3;
    if (rst_n && cmp_on) begin
      chk("R2 line", tx_line, m_line());
      chk("R11 busy", tx_busy, m_active);
      chk("R6 flag", empty_flag, m_flag);
      chk("R7 irq", tx_irq, m_flag && irq_en);
      chk("R9 overrun", overrun, m_ovf);
    end
  end

  // tick-rate line decoder, sampled 2 ns before the edge
  int dpos = 0, dnb = 8, dacc = 0, decoded = 0;
  always @(posedge clk) begin
    #8;
    if (!tx_busy) dpos = 0;
    else if (baud_tick) begin
      if (dpos == 0) begin
        chk("R2 start bit", tx_line, 0);
        dnb = nine_mode ? 9 : 8; dacc = 0;
      end else if (dpos <= dnb) begin
        dacc |= int'(tx_line) << (dpos - 1);
      end else begin
        chk("R2 stop bit", tx_line, 1);
        if (exp_q.size() > 0) begin
          int e;
          e = exp_q.pop_front();
          if (dnb == 9) chk("R3 nine-bit frame", dacc, e);
          else chk("R2 lsb-first data", dacc, e & 8'hFF);
        end else chk("R9 unexpected frame", 1, 0);
        decoded++;
      end
      dpos++;
    end
  end

  task automatic wr(input int d, input bit b9);
    @(negedge clk); wr_stb = 1; wr_data = 8'(d); wr_bit9 = b9;
    @(negedge clk); wr_stb = 0;
  endtask

  task automatic sample();
    @(posedge clk); #3;
  endtask

  task automatic wait_idle();
    do sample(); while (tx_busy || m_q.size() > 0);
  endtask

  task automatic run_tests();
    int d0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    sample();
    chk("R1 reset line", tx_line, 1);
    chk("R11 reset busy", tx_busy, 0);
    chk("R8 reset flag", empty_flag, 0);
    chk("R9 reset overrun", overrun, 0);
    cmp_on = 1;

    // R8: partial enables keep the transmitter off
    @(negedge clk); port_en = 1; tx_en = 0;
    repeat (2) sample();
    chk("R8 flag tx_en=0", empty_flag, 0);
    wr(8'h5A, 0);
    repeat (4) sample();
    chk("R8 write ignored", tx_line, 1);
    @(negedge clk); tx_en = 1; sync_mode = 1;
    repeat (2) sample();
    chk("R8 flag sync_mode=1", empty_flag, 0);
    @(negedge clk); sync_mode = 0;
    sample();
    chk("R8 flag one cycle after enable", empty_flag, 1);
    chk("R7 irq masked", tx_irq, 0);
    @(negedge clk); irq_en = 1;
    sample();
    chk("R7 irq enabled", tx_irq, 1);
    tick_run = 1;

    // R4: immediate handoff latency
    @(negedge clk); wr_stb = 1; wr_data = 8'hA5; wr_bit9 = 0;
    sample();
    chk("R4 line cycle c+1", tx_line, 1);
    @(negedge clk); wr_stb = 0;
    sample();
    chk("R4 line cycle c+2", tx_line, 0);
    chk("R4 busy cycle c+2", tx_busy, 1);
    chk("R6 flag stays set", empty_flag, 1);
    wait_idle();

    // R6: two-cycle flag latency, then R5 back-to-back handoff
    wr(8'h3C, 0);
    repeat (3) sample();
    @(negedge clk); wr_stb = 1; wr_data = 8'hC3;
    sample();
    chk("R6 flag unchanged c+1", empty_flag, 1);
    @(negedge clk); wr_stb = 0;
    sample();
    chk("R6 flag clear c+2", empty_flag, 0);
    chk("R7 irq follows flag", tx_irq, 0);
    do sample(); while (tx_busy);
    chk("R5 one-cycle gap line", tx_line, 1);
    sample();
    chk("R5 start follows", tx_line, 0);
    chk("R5 busy again", tx_busy, 1);
    wait_idle();

    // R3: nine-bit frames
    @(negedge clk); nine_mode = 1;
    wr(8'h81, 1);
    wr(8'h00, 0);
    wait_idle();
    wr(8'hFF, 1);
    wait_idle();
    @(negedge clk); nine_mode = 0;

    // R9: overflow
    d0 = decoded;
    wr(8'h11, 0);
    repeat (3) sample();
    wr(8'h22, 0);
    repeat (2) sample();
    wr(8'h33, 0);
    sample();
    chk("R9 overrun set", overrun, 1);
    wait_idle();
    repeat (8) sample();
    chk("R9 lost write not sent", decoded - d0, 2);
    chk("R9 overrun sticky", overrun, 1);

    // R10: abort mid-frame
    wr(8'h55, 0);
    repeat (10) sample();
    wr(8'h66, 0);
    @(negedge clk); tx_en = 0;
    sample();
    chk("R10 line idle", tx_line, 1);
    chk("R10 busy clear", tx_busy, 0);
    chk("R10 flag clear", empty_flag, 0);
    chk("R10 overrun clear", overrun, 0);
    @(negedge clk); tx_en = 1;
    repeat (6) sample();
    chk("R10 queue dropped", tx_busy, 0);
    chk("R1 idle after abort", tx_line, 1);
    chk("R8 flag back", empty_flag, 1);

    // back-to-back burst, R2/R5 via model and decoder
    for (int i = 0; i < 4; i++) begin
      do sample(); while (!empty_flag);
      wr(8'h0F + 8'(i * 37), 0);
    end
    wait_idle();
    repeat (6) sample();
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule